// File: doc/BRIEF.md
# Vector Saturating Rounding Narrow Shifter

This block takes a 128-bit vector of signed integer lanes and reduces each lane to half its width in a single pass. It adds a rounding constant, shifts each lane right arithmetically by an immediate amount, then clamps the result to the signed range of the narrower lane. The packed lanes are 16, 32 or 64 bits wide, so the narrowed result is always 64 bits.

The 64-bit result is merged into a copy of the current 128-bit destination value. In low mode it fills the bottom half and the top half is zeroed. In high mode it fills the top half and the bottom half keeps the destination's previous contents. A sticky flag records that at least one lane has been clamped since it was last cleared. The result and the flag are registered one cycle after a strobe that marks the inputs as valid.

Top module: `vnarrow_shift`

## Requirements
- R1: While `rst` is high at a clock edge, `dst_out` becomes zero and `sat_flag` becomes 0.
- R2: `esize` selects the source lane width. 0 gives eight 16-bit lanes narrowed to 8 bits. 1 gives four 32-bit lanes narrowed to 16 bits. 2 (and 3) gives two 64-bit lanes narrowed to 32 bits. Narrow lane i comes from source lane i, and lane 0 sits in the least significant bits of the written half.
- R3: For a shift amount s, which is legal from 1 up to the narrow width, each lane's value before clamping is floor((x + 2^(s-1)) / 2^s), where x is the signed source lane. The sum cannot overflow, even for the largest positive source value.
- R4: A value above 2^(n-1)-1 is clamped to 2^(n-1)-1, and a value below -2^(n-1) is clamped to -2^(n-1), where n is the narrow lane width.
- R5: With `upper` = 0, `dst_out[63:0]` gets the narrowed vector and `dst_out[127:64]` is zero.
- R6: With `upper` = 1, `dst_out[127:64]` gets the narrowed vector and `dst_out[63:0]` equals `dst_in[63:0]`.
- R7: `dst_out` is updated on the clock edge where `in_valid` is high, which gives one cycle of latency. It holds its value while `in_valid` is low.
- R8: `sat_flag` is set after a valid operation in which any lane was clamped. It is not cleared by operations that do not clamp.
- R9: `clr_sat` high at a clock edge clears `sat_flag`. If a clamping valid operation arrives in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_sat | input | 1 | Synchronous clear of the sticky flag |
| in_valid | input | 1 | Operation strobe |
| esize | input | 2 | Source lane width select (0:16, 1:32, 2/3:64) |
| shamt | input | 6 | Right shift amount, 1 to the narrow width |
| upper | input | 1 | 1 writes the high half, 0 writes the low half |
| src | input | 128 | Source vector of signed lanes |
| dst_in | input | 128 | Current destination value |
| dst_out | output | 128 | Registered new destination value |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
A flag clear and a clamping operation can land on the same clock edge. The flag must come out set in that case, because the new saturation has to survive the clear. The bench provokes this directly by asserting `clr_sat` together with an operation that clamps, and it also pairs a clear with an operation that does not clamp, where the flag must end at zero. After each case the flag is compared with a bench model that applies the clear first and then ORs in the lane saturation computed by reference functions.

// File: rtl/vnarrow_pkg.sv
package vnarrow_pkg;
    localparam int VEC_W  = 128;
    localparam int HALF_W = VEC_W / 2;
    localparam int SH_W   = 6;

    typedef enum logic [1:0] {
        ES_16 = 2'd0,
        ES_32 = 2'd1,
        ES_64 = 2'd2,
        ES_RSV = 2'd3
    } esize_t;

    typedef struct packed {
        logic [HALF_W-1:0] data;
        logic              sat;
    } narrow_res_t;

    function automatic logic [VEC_W-1:0] merge_half(
        input logic              hi,
        input logic [HALF_W-1:0] nar,
        input logic [HALF_W-1:0] keep_lo
    );
        return hi ? {nar, keep_lo} : {{HALF_W{1'b0}}, nar};
    endfunction
endpackage

// File: rtl/vn_lane.sv
module vn_lane #(
    parameter int SW   = 16,
    parameter int SH_W = 6,
    localparam int NW  = SW / 2
) (
    input  logic [SW-1:0]   a,
    input  logic [SH_W-1:0] sh,
    output logic [NW-1:0]   y,
    output logic            sat
);
    logic signed [SW:0]   ext;
    logic        [SW:0]   rnd;
    logic signed [SW:0]   sum;
    logic signed [SW:0]   shifted;
    logic [SW-NW+1:0]     top;
    logic                 in_range;

    always_comb begin
        ext      = $signed({a[SW-1], a});
        rnd      = (sh == '0) ? '0 : ((SW+1)'(1) << (sh - SH_W'(1)));
        sum      = ext + $signed(rnd);
        shifted  = sum >>> sh;
        top      = shifted[SW:NW-1];
        in_range = (&top) | ~(|top);
        sat      = ~in_range;
        if (in_range)
            y = shifted[NW-1:0];
        else if (shifted[SW])
            y = {1'b1, {(NW-1){1'b0}}};
        else
            y = {1'b0, {(NW-1){1'b1}}};
    end
endmodule

// File: rtl/vn_bank.sv
module vn_bank
    import vnarrow_pkg::*;
#(
    parameter int SW = 16,
    localparam int NW    = SW / 2,
    localparam int LANES = VEC_W / SW
) (
    input  logic [VEC_W-1:0] src,
    input  logic [SH_W-1:0]  sh,
    output narrow_res_t      res
);
    logic [LANES-1:0] lane_sat;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vn_lane #(.SW(SW), .SH_W(SH_W)) u_lane (
            .a   (src[i*SW +: SW]),
            .sh  (sh),
            .y   (res.data[i*NW +: NW]),
            .sat (lane_sat[i])
        );
    end

    assign res.sat = |lane_sat;
endmodule

// File: rtl/vnarrow_shift.sv
module vnarrow_shift
    import vnarrow_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_sat,
    input  logic             in_valid,
    input  logic [1:0]       esize,
    input  logic [5:0]       shamt,
    input  logic             upper,
    input  logic [127:0]     src,
    input  logic [127:0]     dst_in,
    output logic [127:0]     dst_out,
    output logic             sat_flag
);
    narrow_res_t r16, r32, r64, rsel;
    logic        unused_dst_hi;

    vn_bank #(.SW(16)) u_b16 (.src(src), .sh(shamt), .res(r16));
    vn_bank #(.SW(32)) u_b32 (.src(src), .sh(shamt), .res(r32));
    vn_bank #(.SW(64)) u_b64 (.src(src), .sh(shamt), .res(r64));

    assign unused_dst_hi = ^dst_in[VEC_W-1:HALF_W];

    always_comb begin
        case (esize_t'(esize))
            ES_16:   rsel = r16;
            ES_32:   rsel = r32;
            default: rsel = r64;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_out  <= '0;
            sat_flag <= 1'b0;
        end else begin
            if (in_valid)
                dst_out <= merge_half(upper, rsel.data, dst_in[HALF_W-1:0]);
            sat_flag <= (sat_flag & ~clr_sat) | (in_valid & rsel.sat);
        end
    end
endmodule

// File: rtl/vnarrow_chk.sv
module vnarrow_chk (
    input logic         clk,
    input logic         rst,
    input logic         clr_sat,
    input logic         in_valid,
    input logic         upper,
    input logic [127:0] dst_in,
    input logic [127:0] dst_out,
    input logic         sat_flag
);
    AST_LOW_CLEARS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !upper) |=> (dst_out[127:64] == 64'd0)); // R5
    AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && upper) |=> (dst_out[63:0] == $past(dst_in[63:0]))); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(dst_out)); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !clr_sat) |=> sat_flag); // R8
    AST_FLAG_RISE_ON_OP: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_flag) |-> $past(in_valid)); // R8
    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (clr_sat && !in_valid) |=> !sat_flag); // R9
endmodule

bind vnarrow_shift vnarrow_chk u_chk (
    .clk(clk), .rst(rst), .clr_sat(clr_sat), .in_valid(in_valid),
    .upper(upper), .dst_in(dst_in), .dst_out(dst_out), .sat_flag(sat_flag)
);

// File: tb/sim_vnarrow_shift.sv
module sim_vnarrow_shift;
    logic         clk = 0;
    logic         rst = 1;
    logic         clr_sat = 0;
    logic         in_valid = 0;
    logic [1:0]   esize = 0;
    logic [5:0]   shamt = 1;
    logic         upper = 0;
    logic [127:0] src = 0;
    logic [127:0] dst_in = 0;
    logic [127:0] dst_out;
    logic         sat_flag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    bit sat_m = 0;
    logic [127:0] out_m = 0;

    always #4 clk = ~clk;

    vnarrow_shift u0 (.*);

    function automatic logic [63:0] narrow_ref(input logic [127:0] s, input int es,
                                               input int sh, output bit sat);
        int sw = 16 << es;
        int nw = sw / 2;
        int lanes = 128 / sw;
        logic [63:0] r = '0;
        sat = 0;
        for (int i = 0; i < lanes; i++) begin
            logic signed [65:0] x, sum, q, mx, mn;
            for (int b = 0; b < 66; b++)
                x[b] = (b < sw) ? s[i*sw + b] : s[i*sw + sw - 1];
            sum = x + (66'sd1 <<< (sh - 1));
            q   = sum >>> sh;
            mx  = (66'sd1 <<< (nw - 1)) - 66'sd1;
            mn  = -mx - 66'sd1;
            if (q > mx) begin q = mx; sat = 1; end
            else if (q < mn) begin q = mn; sat = 1; end
            for (int b = 0; b < nw; b++) r[i*nw + b] = q[b];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic op(input string tag, input logic [127:0] s, input logic [127:0] d,
                      input int es, input int sh, input bit up, input bit clr);
        bit ls;
        logic [63:0] n;
        n = narrow_ref(s, es, sh, ls);
        @(negedge clk);
        src = s; dst_in = d; esize = 2'(es); shamt = 6'(sh); upper = up;
        clr_sat = clr; in_valid = 1;
        @(negedge clk);
        in_valid = 0; clr_sat = 0;
        out_m = up ? {n, d[63:0]} : {64'd0, n};
        sat_m = (sat_m & ~clr) | ls;
        chk({tag, " data"}, dst_out, out_m);
        chk({tag, " flag"}, {127'd0, sat_flag}, {127'd0, sat_m});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        dst_in = {128{1'b1}}; src = {128{1'b1}};
        repeat (3) @(negedge clk);
        chk("R1 reset data", dst_out, 128'd0);
        chk("R1 reset flag", {127'd0, sat_flag}, 128'd0);
        rst = 0;

        // R2 lane order, exact values, no clamp
        op("R2 es16", {16'd8,16'd7,16'd6,16'd5,16'd4,16'd3,16'd2,16'd1} << 2, 128'd0, 0, 2, 0, 0);
        chk("R2 es16 lanes", dst_out, {64'd0, 64'h08070605_04030201});
        op("R2 es32", {32'd400,32'd300,32'd200,32'd100} << 4, 128'd0, 1, 4, 0, 0);
        op("R2 es64", {64'd77, 64'd55} << 8, 128'd0, 2, 8, 0, 0);
        chk("R2 es64 lanes", dst_out, {64'd0, 32'd77, 32'd55});
        // R3 rounding: 5>>1 -> 3, -5>>1 -> -2
        op("R3 round pos", {112'd0, 16'd5}, 128'd0, 0, 1, 0, 0);
        chk("R3 round pos val", dst_out, 128'd3);
        op("R3 round neg", {112'd0, 16'hFFFB}, 128'd0, 0, 1, 0, 0);
        chk("R3 round neg val", dst_out, {64'd0, 56'd0, 8'hFE});
        // R3/R4 max 64-bit with shift 32 clamps to 0x7FFFFFFF, no wrap
        op("R3 no overflow", {64'd0, 64'h7FFF_FFFF_FFFF_FFFF}, 128'd0, 2, 32, 0, 0);
        chk("R3 no overflow val", dst_out, {64'd0, 32'd0, 32'h7FFF_FFFF});
        // R4 clamps both ways
        op("R4 clamp 16", {96'd0, 16'h8000, 16'h7FFF}, 128'd0, 0, 1, 0, 0);
        chk("R4 clamp 16 val", dst_out, {64'd0, 48'd0, 8'h80, 8'h7F});
        chk("R8 flag set", {127'd0, sat_flag}, 128'd1);
        op("R8 flag sticky", 128'd0, 128'd0, 1, 3, 0, 0);
        chk("R8 flag still", {127'd0, sat_flag}, 128'd1);
        // R5/R6 halves
        op("R5 low half", {128{1'b0}} | 128'h1234, {128{1'b1}}, 1, 16, 0, 0);
        op("R6 high half", 128'h0055_0000_0033, {64'hAAAA, 64'hDEAD_BEEF_0BAD_F00D}, 1, 1, 1, 0);
        // R7 hold while idle
        repeat (3) @(negedge clk);
        src = ~src; dst_in = ~dst_in;
        @(negedge clk);
        chk("R7 idle hold", dst_out, out_m);
        // R9 clear alone
        @(negedge clk); clr_sat = 1; @(negedge clk); clr_sat = 0; sat_m = 0;
        chk("R9 clear", {127'd0, sat_flag}, 128'd0);
        // R9 clear with a clamping op: set wins
        op("R9 clear+sat", {112'd0, 16'h7FFF}, 128'd0, 0, 2, 0, 1);
        chk("R9 clear+sat flag", {127'd0, sat_flag}, 128'd1);
        op("R9 clear+nosat", 128'd0, 128'd0, 0, 2, 0, 1);

        // random mix R2-R6, R8
        for (int k = 0; k < 300; k++) begin
            logic [127:0] s, d;
            int es, sh;
            s = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom % 3 == 0) s = s >> ($urandom % 64);
            d = {$urandom, $urandom, $urandom, $urandom};
            es = int'($urandom % 3);
            sh = 1 + int'($urandom % (8 << es));
            op("R2-random R3 R4 R5 R6", s, d, es, sh, bit'($urandom % 2), bit'($urandom % 8 == 0));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule